// File: doc/BRIEF.md
# Sectored Data Cache with Pair Fill

This block is a direct-mapped data cache whose lines each carry one tag but keep valid and dirty state separately for every 32-byte sector. A client sends read or write requests for one sector at a time; writes carry per-byte enables. Reads hit or miss per sector. On a miss the cache asks backing memory for an aligned 64-byte block covering the requested sector and its paired neighbour. Status and writes therefore stay at sector size while fetches use twice that size.

A sector-miss counter goes up by one for each sector a fill brings in, which is two per fill, even when the client only wanted one of them. A hit counter goes up once per request served without a fill. When a request maps to a line that holds a different tag, every dirty sector of that line is written back, one sector per memory request and lowest sector first. The line is then cleared and the pair fill follows. Only one miss is handled at a time.

Back-pressure: a request transfers when `req_valid` and `req_ready` are both high at a clock edge. A read response is held with stable data until `rsp_ready` is seen. A memory request is held with stable address, kind and data until `mem_req_ready` is seen. Fill data transfers when `mem_fill_valid` and `mem_fill_ready` are both high.

Top module: `sectored_cache`

## Requirements
- R1: The address is decoded as tag = addr[31:11], line = addr[10:7], sector = addr[6:5] and byte offset = addr[4:0]. There are 16 lines of four sectors each, and each line holds exactly one tag.
- R2: A read hit (tag equal and sector valid) raises `rsp_valid` in the cycle after acceptance, with the sector's current contents. Byte b of the sector is on bits [8b+7:8b]. `hit_count` increases by one.
- R3: A miss issues exactly one read memory request. Its address has bits [5:0] zero and bit 6 equal to the requested sector's bit 1. `sector_miss_count` increases by two when that request is accepted.
- R4: After a pair fill, an access to the other sector of the pair is a hit. It causes no memory traffic and counts in `hit_count`.
- R5: A write hit replaces only the bytes whose `req_be` bit is set. It marks that sector dirty, counts one hit and makes no memory request.
- R6: A write miss first fills the pair and then merges the write data under the byte enables, marking only the written sector dirty. It counts two sector misses and no hit.
- R7: On a tag mismatch, each dirty sector of the old line is written back before the fill, in ascending sector order. Each write-back uses the old tag, the line and the sector in its address, and the sector's data. A line with no dirty sector causes no write-back.
- R8: `req_ready` is low from the acceptance of a missing request until its fill is installed and the request is completed. It is also low while a read response waits.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` stays high and `rsp_rdata` does not change.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, `mem_req_valid`, `mem_req_write`, `mem_req_addr` and `mem_req_wdata` do not change.
- R11: After reset both counters are zero, no line is valid, `req_ready` is high and `rsp_valid` and `mem_req_valid` are low.
- R12: A sweep of reads at a 64-byte stride over unfilled lines makes one fill and two counted misses per request. A sweep at a 32-byte stride makes one fill and two misses per pair of requests, with the second request of each pair a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Cache can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address of the request |
| req_wdata | input | 256 | Write data for one sector |
| req_be | input | 32 | Byte enables for the write |
| rsp_valid | output | 1 | Read data available |
| rsp_ready | input | 1 | Client takes read data |
| rsp_rdata | output | 256 | Read data of one sector |
| mem_req_valid | output | 1 | Memory request offered |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_write | output | 1 | 1 = sector write-back, 0 = 64-byte fill read |
| mem_req_addr | output | 32 | Byte address of the memory request |
| mem_req_wdata | output | 256 | Write-back data |
| mem_fill_valid | input | 1 | Fill data offered |
| mem_fill_ready | output | 1 | Cache waits for fill data |
| mem_fill_data | input | 512 | Fill data, lower-addressed sector in bits [255:0] |
| hit_count | output | 32 | Requests served without a fill |
| sector_miss_count | output | 32 | Sectors brought in by fills |

## Verification
The hardest state to reach is a victim line with more than one dirty sector in different halves. Only then do the ordering and address of successive write-backs show. The bench first dirties the upper pair of a line with a write miss and then the lower pair with a second write miss under the same tag. Next it reads an address with the same line and a new tag, and checks the order and payload of both write-backs as the memory model receives them. A later refetch of the written-back sector checks the data returned through a fill. The memory model stalls every request for one cycle, so the hold rules apply to each write-back and fill.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int SEC_BYTES = 32;
  localparam int SECS_PER_LINE = 4;
  localparam int SEC_BITS = SEC_BYTES * 8;
  localparam int OFF_W = $clog2(SEC_BYTES);
  localparam int SIDX_W = $clog2(SECS_PER_LINE);
  localparam int PAIR_BITS = 2 * SEC_BITS;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WB,
    ST_FILL_REQ,
    ST_FILL_WAIT,
    ST_DONE,
    ST_RESP
  } cache_state_e;
endpackage

// File: rtl/sc_status_store.sv
module sc_status_store
  import sc_pkg::*;
#(
  parameter int LINES = 16,
  parameter int TAG_W = 21,
  localparam int LI_W = $clog2(LINES)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [LI_W-1:0]          lk_line,
  output logic [TAG_W-1:0]         lk_tag,
  output logic [SECS_PER_LINE-1:0] lk_valid,
  output logic [SECS_PER_LINE-1:0] lk_dirty,
  input  logic                     evict_en,
  input  logic [LI_W-1:0]          evict_line,
  input  logic [TAG_W-1:0]         evict_tag,
  input  logic                     fill_en,
  input  logic [LI_W-1:0]          fill_line,
  input  logic                     fill_pair,
  input  logic                     mark_en,
  input  logic [LI_W-1:0]          mark_line,
  input  logic [SIDX_W-1:0]        mark_sec
);
  logic [TAG_W-1:0]         tag_q   [LINES];
  logic [SECS_PER_LINE-1:0] valid_q [LINES];
  logic [SECS_PER_LINE-1:0] dirty_q [LINES];

  assign lk_tag   = tag_q[lk_line];
  assign lk_valid = valid_q[lk_line];
  assign lk_dirty = dirty_q[lk_line];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int l = 0; l < LINES; l++) begin
        tag_q[l]   <= '0;
        valid_q[l] <= '0;
        dirty_q[l] <= '0;
      end
    end else begin
      if (evict_en) begin
        tag_q[evict_line]   <= evict_tag;
        valid_q[evict_line] <= '0;
        dirty_q[evict_line] <= '0;
      end
      if (fill_en) begin
        for (int h = 0; h < 2; h++) begin
          if (!(valid_q[fill_line][{fill_pair, h[0]}] && dirty_q[fill_line][{fill_pair, h[0]}])) begin
            valid_q[fill_line][{fill_pair, h[0]}] <= 1'b1;
            dirty_q[fill_line][{fill_pair, h[0]}] <= 1'b0;
          end
        end
      end
      if (mark_en) dirty_q[mark_line][mark_sec] <= 1'b1;
    end
  end

  // A fill is only issued when its pair has a sector that is not present.
  assert_fill_has_gap_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |-> !(valid_q[fill_line][{fill_pair, 1'b0}] && valid_q[fill_line][{fill_pair, 1'b1}]));

  // Dirty marking only lands on a sector that holds data.
  assert_mark_valid_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    mark_en |-> valid_q[mark_line][mark_sec]);
endmodule

// File: rtl/sc_data_store.sv
module sc_data_store
  import sc_pkg::*;
#(
  parameter int LINES = 16,
  localparam int LI_W = $clog2(LINES),
  localparam int IDX_W = LI_W + SIDX_W,
  localparam int DEPTH = LINES * SECS_PER_LINE
) (
  input  logic                 clk,
  input  logic [LI_W-1:0]      rd_line,
  input  logic [SIDX_W-1:0]    rd_sec,
  output logic [SEC_BITS-1:0]  rd_data,
  input  logic                 fill_en,
  input  logic [LI_W-1:0]      fill_line,
  input  logic                 fill_pair,
  input  logic [1:0]           fill_keep,
  input  logic [PAIR_BITS-1:0] fill_data,
  input  logic                 wr_en,
  input  logic [LI_W-1:0]      wr_line,
  input  logic [SIDX_W-1:0]    wr_sec,
  input  logic [SEC_BITS-1:0]  wr_data,
  input  logic [SEC_BYTES-1:0] wr_be
);
  logic [SEC_BITS-1:0] mem_q [DEPTH];

  assign rd_data = mem_q[IDX_W'({rd_line, rd_sec})];

  always_ff @(posedge clk) begin
    if (fill_en) begin
      for (int h = 0; h < 2; h++) begin
        if (!fill_keep[h])
          mem_q[IDX_W'({fill_line, fill_pair, h[0]})] <= fill_data[h*SEC_BITS +: SEC_BITS];
      end
    end
    if (wr_en) begin
      for (int b = 0; b < SEC_BYTES; b++) begin
        if (wr_be[b])
          mem_q[IDX_W'({wr_line, wr_sec})][8*b +: 8] <= wr_data[8*b +: 8];
      end
    end
  end
endmodule

// File: rtl/sc_ctrl.sv
module sc_ctrl
  import sc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINES = 16,
  parameter int CNT_W = 32,
  localparam int LI_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - OFF_W - SIDX_W - LI_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [SEC_BITS-1:0]      req_wdata,
  input  logic [SEC_BYTES-1:0]     req_be,
  output logic                     rsp_valid,
  input  logic                     rsp_ready,
  output logic [SEC_BITS-1:0]      rsp_rdata,
  output logic                     mem_req_valid,
  input  logic                     mem_req_ready,
  output logic                     mem_req_write,
  output logic [ADDR_W-1:0]        mem_req_addr,
  output logic [SEC_BITS-1:0]      mem_req_wdata,
  input  logic                     mem_fill_valid,
  output logic                     mem_fill_ready,
  output logic [CNT_W-1:0]         hit_count,
  output logic [CNT_W-1:0]         sector_miss_count,
  // status store
  output logic [LI_W-1:0]          lk_line,
  input  logic [TAG_W-1:0]         lk_tag,
  input  logic [SECS_PER_LINE-1:0] lk_valid,
  input  logic [SECS_PER_LINE-1:0] lk_dirty,
  output logic                     evict_en,
  output logic [TAG_W-1:0]         evict_tag,
  output logic                     fill_en,
  output logic                     fill_pair,
  output logic [1:0]               fill_keep,
  output logic                     mark_en,
  output logic [SIDX_W-1:0]        mark_sec,
  // data store
  output logic [LI_W-1:0]          rd_line,
  output logic [SIDX_W-1:0]        rd_sec,
  input  logic [SEC_BITS-1:0]      rd_data,
  output logic                     wr_en,
  output logic [LI_W-1:0]          wr_line,
  output logic [SIDX_W-1:0]        wr_sec,
  output logic [SEC_BITS-1:0]      wr_data,
  output logic [SEC_BYTES-1:0]     wr_be
);
  cache_state_e state_q;

  logic                     r_write;
  logic [LI_W-1:0]          r_line;
  logic [SIDX_W-1:0]        r_sec;
  logic [TAG_W-1:0]         r_tag;
  logic [SEC_BITS-1:0]      r_wdata;
  logic [SEC_BYTES-1:0]     r_be;
  logic                     r_evict;
  logic [SECS_PER_LINE-1:0] wb_mask;
  logic [SEC_BITS-1:0]      rsp_q;
  logic [CNT_W-1:0]         hit_q;
  logic [CNT_W-1:0]         miss_q;

  // request address fields
  logic [TAG_W-1:0]  in_tag;
  logic [LI_W-1:0]   in_line;
  logic [SIDX_W-1:0] in_sec;
  assign in_tag  = req_addr[ADDR_W-1 -: TAG_W];
  assign in_line = req_addr[OFF_W+SIDX_W +: LI_W];
  assign in_sec  = req_addr[OFF_W +: SIDX_W];

  logic accept, lookup_hit, lookup_evict;
  assign accept       = req_valid && (state_q == ST_IDLE);
  assign lookup_hit   = lk_valid[in_sec] && (lk_tag == in_tag);
  assign lookup_evict = (lk_tag != in_tag) || (lk_valid == '0);

  function automatic logic [SIDX_W-1:0] lowest_set(input logic [SECS_PER_LINE-1:0] m);
    logic [SIDX_W-1:0] idx;
    idx = '0;
    for (int i = SECS_PER_LINE - 1; i >= 0; i--) begin
      if (m[i]) idx = SIDX_W'(i);
    end
    return idx;
  endfunction

  logic [SIDX_W-1:0] wb_sec;
  assign wb_sec = lowest_set(wb_mask);

  // status/data selection
  always_comb begin
    lk_line = (state_q == ST_IDLE) ? in_line : r_line;
    rd_line = lk_line;
    unique case (state_q)
      ST_IDLE: rd_sec = in_sec;
      ST_WB:   rd_sec = wb_sec;
      default: rd_sec = r_sec;
    endcase
  end

  always_comb begin
    wr_en    = 1'b0;
    wr_line  = r_line;
    wr_sec   = r_sec;
    wr_data  = r_wdata;
    wr_be    = r_be;
    mark_en  = 1'b0;
    mark_sec = r_sec;
    if (state_q == ST_IDLE) begin
      wr_en    = accept && lookup_hit && req_write;
      wr_line  = in_line;
      wr_sec   = in_sec;
      wr_data  = req_wdata;
      wr_be    = req_be;
      mark_en  = wr_en;
      mark_sec = in_sec;
    end else if (state_q == ST_DONE && r_write) begin
      wr_en   = 1'b1;
      mark_en = 1'b1;
    end
  end

  // memory side
  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_write = 1'b0;
    mem_req_addr  = '0;
    mem_req_wdata = rd_data;
    if (state_q == ST_WB) begin
      mem_req_valid = |wb_mask;
      mem_req_write = 1'b1;
      mem_req_addr  = {lk_tag, r_line, wb_sec, {OFF_W{1'b0}}};
    end else if (state_q == ST_FILL_REQ) begin
      mem_req_valid = 1'b1;
      mem_req_addr  = {r_tag, r_line, r_sec[SIDX_W-1], {(OFF_W+1){1'b0}}};
    end
  end

  assign mem_fill_ready = (state_q == ST_FILL_WAIT);
  assign fill_en        = mem_fill_ready && mem_fill_valid;
  assign fill_pair      = r_sec[SIDX_W-1];
  assign fill_keep[0]   = lk_valid[{fill_pair, 1'b0}] && lk_dirty[{fill_pair, 1'b0}];
  assign fill_keep[1]   = lk_valid[{fill_pair, 1'b1}] && lk_dirty[{fill_pair, 1'b1}];
  assign evict_en       = (state_q == ST_WB) && (wb_mask == '0) && r_evict;
  assign evict_tag      = r_tag;

  assign req_ready         = (state_q == ST_IDLE);
  assign rsp_valid         = (state_q == ST_RESP);
  assign rsp_rdata         = rsp_q;
  assign hit_count         = hit_q;
  assign sector_miss_count = miss_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      r_write <= 1'b0;
      r_line  <= '0;
      r_sec   <= '0;
      r_tag   <= '0;
      r_wdata <= '0;
      r_be    <= '0;
      r_evict <= 1'b0;
      wb_mask <= '0;
      rsp_q   <= '0;
      hit_q   <= '0;
      miss_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (lookup_hit) begin
              hit_q <= hit_q + CNT_W'(1);
              if (!req_write) begin
                rsp_q   <= rd_data;
                state_q <= ST_RESP;
              end
            end else begin
              r_write <= req_write;
              r_line  <= in_line;
              r_sec   <= in_sec;
              r_tag   <= in_tag;
              r_wdata <= req_wdata;
              r_be    <= req_be;
              r_evict <= lookup_evict;
              wb_mask <= lookup_evict ? lk_dirty : '0;
              state_q <= ST_WB;
            end
          end
        end
        ST_WB: begin
          if (wb_mask == '0) state_q <= ST_FILL_REQ;
          else if (mem_req_ready) wb_mask[wb_sec] <= 1'b0;
        end
        ST_FILL_REQ: begin
          if (mem_req_ready) begin
            miss_q  <= miss_q + CNT_W'(2);
            state_q <= ST_FILL_WAIT;
          end
        end
        ST_FILL_WAIT: begin
          if (mem_fill_valid) state_q <= ST_DONE;
        end
        ST_DONE: begin
          if (r_write) state_q <= ST_IDLE;
          else begin
            rsp_q   <= rd_data;
            state_q <= ST_RESP;
          end
        end
        ST_RESP: begin
          if (rsp_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_rsp_hold_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  assert_mem_hold_R10 : assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) && $stable(mem_req_wdata)));

  assert_busy_blocks_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid || mem_fill_ready) |-> !req_ready);

  assert_fill_aligned_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_write) |-> (mem_req_addr[OFF_W:0] == '0));

  assert_wb_aligned_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write) |-> (mem_req_addr[OFF_W-1:0] == '0));

  assert_miss_step_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    (sector_miss_count != $past(sector_miss_count)) |->
      (sector_miss_count == $past(sector_miss_count) + CNT_W'(2)));

  assert_hit_step_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    (hit_count != $past(hit_count)) |-> (hit_count == $past(hit_count) + CNT_W'(1)));
endmodule

// File: rtl/sectored_cache.sv
module sectored_cache
  import sc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINE_COUNT = 16,
  parameter int CNT_W = 32,
  localparam int LI_W = $clog2(LINE_COUNT),
  localparam int TAG_W = ADDR_W - OFF_W - SIDX_W - LI_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [SEC_BITS-1:0]  req_wdata,
  input  logic [SEC_BYTES-1:0] req_be,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [SEC_BITS-1:0]  rsp_rdata,
  output logic                 mem_req_valid,
  input  logic                 mem_req_ready,
  output logic                 mem_req_write,
  output logic [ADDR_W-1:0]    mem_req_addr,
  output logic [SEC_BITS-1:0]  mem_req_wdata,
  input  logic                 mem_fill_valid,
  output logic                 mem_fill_ready,
  input  logic [PAIR_BITS-1:0] mem_fill_data,
  output logic [CNT_W-1:0]     hit_count,
  output logic [CNT_W-1:0]     sector_miss_count
);
  logic [LI_W-1:0]          lk_line;
  logic [TAG_W-1:0]         lk_tag;
  logic [SECS_PER_LINE-1:0] lk_valid, lk_dirty;
  logic                     evict_en, fill_en, fill_pair, mark_en, wr_en;
  logic [TAG_W-1:0]         evict_tag;
  logic [1:0]               fill_keep;
  logic [SIDX_W-1:0]        mark_sec, rd_sec, wr_sec;
  logic [LI_W-1:0]          rd_line, wr_line;
  logic [SEC_BITS-1:0]      rd_data, wr_data;
  logic [SEC_BYTES-1:0]     wr_be;

  sc_ctrl #(.ADDR_W(ADDR_W), .LINES(LINE_COUNT), .CNT_W(CNT_W)) u_ctrl (
    .clk, .rst_n,
    .req_valid, .req_ready, .req_write, .req_addr, .req_wdata, .req_be,
    .rsp_valid, .rsp_ready, .rsp_rdata,
    .mem_req_valid, .mem_req_ready, .mem_req_write, .mem_req_addr, .mem_req_wdata,
    .mem_fill_valid, .mem_fill_ready,
    .hit_count, .sector_miss_count,
    .lk_line, .lk_tag, .lk_valid, .lk_dirty,
    .evict_en, .evict_tag, .fill_en, .fill_pair, .fill_keep, .mark_en, .mark_sec,
    .rd_line, .rd_sec, .rd_data, .wr_en, .wr_line, .wr_sec, .wr_data, .wr_be
  );

  sc_status_store #(.LINES(LINE_COUNT), .TAG_W(TAG_W)) u_status (
    .clk, .rst_n,
    .lk_line, .lk_tag, .lk_valid, .lk_dirty,
    .evict_en, .evict_line(lk_line), .evict_tag,
    .fill_en, .fill_line(lk_line), .fill_pair,
    .mark_en, .mark_line(wr_line), .mark_sec
  );

  sc_data_store #(.LINES(LINE_COUNT)) u_data (
    .clk,
    .rd_line, .rd_sec, .rd_data,
    .fill_en, .fill_line(lk_line), .fill_pair, .fill_keep, .fill_data(mem_fill_data),
    .wr_en, .wr_line, .wr_sec, .wr_data, .wr_be
  );
endmodule

// File: tb/test_sectored_cache.sv
`timescale 1ns/1ps
module test_sectored_cache;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0, req_write = 1'b0;
  logic [31:0]  req_addr = '0;
  logic [255:0] req_wdata = '0;
  logic [31:0]  req_be = '0;
  logic         req_ready, rsp_valid;
  logic         rsp_ready = 1'b1;
  logic [255:0] rsp_rdata;
  logic         mem_req_valid, mem_req_write, mem_fill_ready;
  logic         mem_req_ready = 1'b0, mem_fill_valid = 1'b0;
  logic [31:0]  mem_req_addr;
  logic [255:0] mem_req_wdata;
  logic [511:0] mem_fill_data = '0;
  logic [31:0]  hit_count, sector_miss_count;

  always #2.5 clk = ~clk;

  sectored_cache i_sectored_cache (
    .clk, .rst_n, .req_valid, .req_ready, .req_write, .req_addr, .req_wdata, .req_be,
    .rsp_valid, .rsp_ready, .rsp_rdata,
    .mem_req_valid, .mem_req_ready, .mem_req_write, .mem_req_addr, .mem_req_wdata,
    .mem_fill_valid, .mem_fill_ready, .mem_fill_data, .hit_count, .sector_miss_count
  );

  int errors = 0, checks = 0;
  int fills = 0, wbs = 0;
  int exp_hit = 0, exp_miss = 0;
  logic [255:0] exp_q[$];
  logic [31:0]  wb_q[$];
  logic [255:0] shadow[logic [31:0]];
  logic [255:0] bmem[logic [31:0]];

  function automatic logic [255:0] pat(input logic [31:0] sa);
    logic [255:0] v;
    for (int k = 0; k < 8; k++) v[32*k +: 32] = (sa << 8) ^ 32'(k) ^ 32'h5A00_0000;
    return v;
  endfunction

  function automatic logic [255:0] view(input logic [31:0] sa);
    return shadow.exists(sa) ? shadow[sa] : pat(sa);
  endfunction

  function automatic logic [255:0] backing(input logic [31:0] sa);
    return bmem.exists(sa) ? bmem[sa] : pat(sa);
  endfunction

  task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: pushes expected read data into the scoreboard queue
  task automatic issue(input bit wr, input logic [31:0] a, input logic [255:0] wd, input logic [31:0] be);
    logic [255:0] m;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd; req_be = be;
    if (wr) begin
      m = view(a >> 5);
      for (int b = 0; b < 32; b++) if (be[b]) m[8*b +: 8] = wd[8*b +: 8];
      shadow[a >> 5] = m;
    end else exp_q.push_back(view(a >> 5));
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (!req_ready) @(negedge clk);
  endtask

  task automatic check_counts(input string req);
    wait_idle();
    check({req, " hit_count"}, 256'(hit_count), 256'(exp_hit));
    check({req, " sector_miss_count"}, 256'(sector_miss_count), 256'(exp_miss));
  endtask

  // monitor: pops and compares read responses
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) check("R2 unexpected response", rsp_rdata, '0 - 1);
      else check("R2 read data", rsp_rdata, exp_q.pop_front());
    end
  end

  // backing memory model: one stall cycle per request (R10)
  initial begin
    logic [31:0]  a;
    logic         w;
    logic [255:0] d;
    forever begin
      @(negedge clk);
      if (rst_n && mem_req_valid) begin
        a = mem_req_addr; w = mem_req_write; d = mem_req_wdata;
        @(negedge clk);
        check("R10 held request", {mem_req_valid, mem_req_write, mem_req_addr, mem_req_wdata[221:0]},
              {1'b1, w, a, d[221:0]});
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        if (w) begin
          wbs++;
          bmem[a >> 5] = d;
          wb_q.push_back(a);
        end else begin
          fills++;
          check("R3 fill alignment", 256'(a[5:0]), 256'(0));
          repeat (2) @(negedge clk);
          mem_fill_data = {backing((a >> 5) + 1), backing(a >> 5)};
          mem_fill_valid = 1'b1;
          while (!mem_fill_ready) @(negedge clk);
          @(negedge clk);
          mem_fill_valid = 1'b0;
        end
      end
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int f0, w0;
    logic [255:0] wd;
    repeat (4) @(negedge clk);
    // R11 reset state
    check("R11 req_ready", 256'(req_ready), 256'(1));
    check("R11 rsp_valid", 256'(rsp_valid), 256'(0));
    check("R11 mem_req_valid", 256'(mem_req_valid), 256'(0));
    check("R11 counters", 256'({hit_count, sector_miss_count}), 256'(0));
    rst_n = 1'b1;

    // R3 R8 first read miss, line 0 sector 0
    issue(0, 32'h0000_0000, '0, '0);
    check("R8 ready low during miss", 256'(req_ready), 256'(0));
    exp_miss += 2;
    check_counts("R3");
    check("R3 one fill", 256'(fills), 256'(1));

    // R4 R2 partner sector hits, response one cycle after accept
    issue(0, 32'h0000_0020, '0, '0);
    check("R2 rsp_valid next cycle", 256'(rsp_valid), 256'(1));
    exp_hit += 1;
    check_counts("R4");
    check("R4 no fill", 256'(fills), 256'(1));

    // R12 64-byte stride over lines 2..5 (R1 mapping)
    f0 = fills;
    for (int i = 0; i < 8; i++) issue(0, 32'h100 + 32'(64 * i), '0, '0);
    exp_miss += 16;
    check_counts("R12 stride 64");
    check("R12 stride 64 fills", 256'(fills - f0), 256'(8));

    // R12 32-byte stride over lines 8..9
    f0 = fills;
    for (int i = 0; i < 8; i++) issue(0, 32'h400 + 32'(32 * i), '0, '0);
    exp_miss += 8; exp_hit += 4;
    check_counts("R12 stride 32");
    check("R12 stride 32 fills", 256'(fills - f0), 256'(4));

    // R5 write hit with partial enables
    f0 = fills; w0 = wbs;
    wd = {8{32'hDEAD_BEEF}};
    issue(1, 32'h0000_0020, wd, 32'h0000_F00F);
    exp_hit += 1;
    check_counts("R5 write hit");
    check("R5 no memory traffic", 256'({fills - f0, wbs - w0}), 256'(0));
    issue(0, 32'h0000_0020, '0, '0);
    exp_hit += 1;
    check_counts("R5 read back");

    // R6 write miss line 12 sector 2
    wd = {8{32'h1234_5678}};
    issue(1, 32'h0000_0640, wd, 32'hFF00_0001);
    exp_miss += 2;
    check_counts("R6 write miss");
    issue(0, 32'h0000_0640, '0, '0);
    issue(0, 32'h0000_0660, '0, '0);
    exp_hit += 2;
    check_counts("R6 merged and partner");

    // R7 eviction of line 0 with one dirty sector
    w0 = wbs;
    issue(0, 32'h0000_0800, '0, '0);
    exp_miss += 2;
    check_counts("R7 evict one dirty");
    check("R7 one write-back", 256'(wbs - w0), 256'(1));
    check("R7 write-back address", 256'(wb_q.pop_front()), 256'(32'h20));
    check("R7 write-back data", backing(32'h20 >> 5), view(32'h20 >> 5));
    issue(0, 32'h0000_0020, '0, '0);
    exp_miss += 2;
    check_counts("R7 refetch written-back sector");

    // R7 two dirty sectors in line 12, ascending order
    wd = {8{32'hCAFE_0001}};
    issue(1, 32'h0000_0600, wd, 32'hFFFF_FFFF);
    exp_miss += 2;
    w0 = wbs;
    issue(0, 32'h0000_0E40, '0, '0);
    exp_miss += 2;
    check_counts("R7 evict two dirty");
    check("R7 two write-backs", 256'(wbs - w0), 256'(2));
    check("R7 first sector", 256'(wb_q.pop_front()), 256'(32'h600));
    check("R7 second sector", 256'(wb_q.pop_front()), 256'(32'h640));
    check("R7 sector 0 data", backing(32'h600 >> 5), view(32'h600 >> 5));
    check("R7 sector 2 data", backing(32'h640 >> 5), view(32'h640 >> 5));

    // R7 clean victim: no write-back
    w0 = wbs;
    issue(0, 32'h0000_0900, '0, '0);
    exp_miss += 2;
    check_counts("R7 clean evict");
    check("R7 clean no write-back", 256'(wbs - w0), 256'(0));

    // R9 R8 response back-pressure on a hit
    rsp_ready = 1'b0;
    issue(0, 32'h0000_0900, '0, '0);
    repeat (4) @(negedge clk);
    check("R9 rsp held", {255'(0), rsp_valid}, 256'(1));
    check("R9 rsp data", rsp_rdata, view(32'h900 >> 5));
    check("R8 ready low while response waits", 256'(req_ready), 256'(0));
    rsp_ready = 1'b1;
    exp_hit += 1;
    check_counts("R9");

    repeat (4) @(negedge clk);
    check("R2 scoreboard drained", 256'(exp_q.size()), 256'(0));
    finish_run();
  end
endmodule